// File: doc/BRIEF.md
# Strobe-Handshaked Parallel Input Port

This block is the receive side of a peripheral data port. A peripheral drives an 8-bit word onto the port pins and pulls a strobe low. While the strobe is low and the port can accept data, the word is captured into a holding register. When the strobe returns high, the capture is committed. The port then marks itself full, withdraws its ready indication and can raise an interrupt request to the processor.

The processor reads the holding register through a qualified I/O read. When that read ends, the port is empty again and ready returns. Ready is forced low for the whole duration of any processor read, so a peripheral that strobes only while ready is high can never change the register under the processor's feet. Ready is the only signal timed on the falling clock edge. Everything else is updated on the rising edge of the single clock.

Top module: `hs_input_port`

## Requirements
- R1: On a rising clock edge where strobe is low, ready is high and no processor read is active, the port pins are copied into the holding register, and `cpu_data` shows them after that edge.
- R2: A strobe low level seen while ready is low, or while a processor read is active, leaves the holding register unchanged.
- R3: A low-to-high strobe transition that follows at least one capture marks the port full, and ready goes low on the next falling clock edge. A transition with no capture since the previous one has no effect.
- R4: A processor read is active only when `cpu_rd_n`, `cpu_ce_n` and `cpu_iorq_n` are all low and `cpu_dsel` is high (1 = data register). Any other combination has no effect on ready or on the full state.
- R5: On every falling clock edge where a processor read is active, ready is driven low, whether or not the port is full.
- R6: The rising edge after a processor read ends clears the full state. Ready then goes high on the following falling edge, provided no read is active.
- R7: A committed strobe (R3) sets a pending interrupt, but only if interrupts are enabled. `int_req` is high exactly when an interrupt is pending and `prio_in` is high.
- R8: `int_ack` clears the pending interrupt on the next rising edge. If a committed strobe occurs in the same cycle, the pending interrupt stays set.
- R9: While `rst_n` is low at a clock edge, the register clears to 0, ready goes high, and both the pending interrupt and the interrupt enable clear.
- R10: When `ien_load` is high at a rising edge, the interrupt enable takes the value of `ien_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; ready updates on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_d | input | 8 | Data pins from the peripheral |
| strb_n | input | 1 | Peripheral strobe, active low |
| rdy_o | output | 1 | High when the port can accept a new word |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_ce_n | input | 1 | Chip enable, active low |
| cpu_dsel | input | 1 | Register select, 1 = data register |
| cpu_iorq_n | input | 1 | I/O request, active low |
| cpu_data | output | 8 | Contents of the holding register |
| ien_load | input | 1 | Write strobe for the interrupt enable |
| ien_value | input | 1 | Value written to the interrupt enable |
| prio_in | input | 1 | High when this port currently has interrupt priority |
| int_ack | input | 1 | Clears a pending interrupt |
| int_req | output | 1 | Interrupt request |

## Verification
The bench goes after strobes that arrive while ready is low. A design that ignored the inhibit would overwrite the unread word, and one that committed such an uncaptured rise would raise a second interrupt. It starts a strobe in the same cycle as a processor read and holds the strobe low across the end of a read. A design that does not block loads during the access would corrupt the register being read. It also issues near-miss reads with chip enable or data select inactive, which a loose decoder would mistake for a real read and use to empty the port. Finally, it checks an acknowledge that coincides with a new committed strobe, a disabled interrupt enable, a masked priority input, and a reset in the middle of a run. A design that let the acknowledge win would lose that interrupt, and one that kept the enable through reset would request an interrupt afterwards.

// File: rtl/hsp_pkg.sv
// Shared definitions for the handshaked input port.
// Assumes all processor bus inputs are synchronous to the port clock.
package hsp_pkg;

    localparam int unsigned HSP_DATA_W = 8;

    // Decodes a qualified processor read of the data register.
    function automatic logic cpu_read_active(
        input logic rd_n,
        input logic ce_n,
        input logic dsel,
        input logic iorq_n
    );
        return (!rd_n) && (!ce_n) && dsel && (!iorq_n);
    endfunction

endpackage

// File: rtl/hsp_edge_det.sv
// Single-bit edge detector.
// Registers the input on the rising clock edge and flags either a rising
// or a falling transition, chosen by parameter. Assumes a synchronous input.
module hsp_edge_det #(
    parameter bit RST_VAL     = 1'b0,
    parameter bit DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);
    logic prev_q;

    // Remember the previous level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig;
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign pulse = sig & ~prev_q;
        end else begin : g_fall
            assign pulse = ~sig & prev_q;
        end
    endgenerate
endmodule

// File: rtl/hsp_in_reg.sv
// Input holding register.
// Captures the pins while the strobe is low and loading is permitted.
// Tracks whether a capture happened since the last strobe rise, so that
// only a rise ending a real capture is reported as committed.
module hsp_in_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strb_n,
    input  logic [W-1:0] port_d,
    input  logic         ready,
    input  logic         cpu_read,
    input  logic         strb_rise,
    output logic [W-1:0] data_q,
    output logic         commit
);
    logic armed_q;
    logic load;

    assign load   = !strb_n && ready && !cpu_read;
    assign commit = strb_rise && armed_q;

    // Capture the pins when loading is permitted.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= port_d;
    end

    // Note whether the current strobe pulse captured anything.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (load)      armed_q <= 1'b1;
        else if (strb_rise) armed_q <= 1'b0;
    end
endmodule

// File: rtl/hsp_ready_ctrl.sv
// Full state and ready output.
// The full flag updates on the rising edge. Ready is recomputed on each
// falling edge from the full flag and the live read decode. Ready therefore
// drops one half-cycle after a commit and is held low during any read.
module hsp_ready_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic read_done,
    input  logic cpu_read,
    output logic ready
);
    logic full_q;

    // Set on a committed strobe, clear when a read finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)         full_q <= 1'b0;
        else if (commit)    full_q <= 1'b1;
        else if (read_done) full_q <= 1'b0;
    end

    // Ready changes only on the falling clock edge.
    always_ff @(negedge clk) begin
        if (!rst_n) ready <= 1'b1;
        else        ready <= !full_q && !cpu_read;
    end
endmodule

// File: rtl/hsp_irq_ctrl.sv
// Interrupt enable and pending request.
// A committed strobe sets the pending flag when enabled. An acknowledge
// clears it, and a simultaneous commit wins. The request is gated by
// the priority input.
module hsp_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ien_load,
    input  logic ien_value,
    input  logic commit,
    input  logic int_ack,
    input  logic prio_in,
    output logic int_req
);
    logic ien_q;
    logic pend_q;

    // Interrupt enable written by the processor side.
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_q <= 1'b0;
        else if (ien_load) ien_q <= ien_value;
    end

    // Pending request: set by an enabled commit, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (commit && ien_q)  pend_q <= 1'b1;
        else if (int_ack)          pend_q <= 1'b0;
    end

    assign int_req = pend_q && prio_in;
endmodule

// File: rtl/hs_input_port.sv
// Handshaked parallel input port, top level.
// Joins the strobe and read edge detectors, the holding register, the
// ready logic and the interrupt logic. Assumes every input is synchronous
// to clk and the peripheral strobes only while rdy_o is high.
module hs_input_port #(
    parameter int unsigned DATA_W = hsp_pkg::HSP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] port_d,
    input  logic              strb_n,
    output logic              rdy_o,
    input  logic              cpu_rd_n,
    input  logic              cpu_ce_n,
    input  logic              cpu_dsel,
    input  logic              cpu_iorq_n,
    output logic [DATA_W-1:0] cpu_data,
    input  logic              ien_load,
    input  logic              ien_value,
    input  logic              prio_in,
    input  logic              int_ack,
    output logic              int_req
);
    logic rd_act;
    logic strb_rise;
    logic read_done;
    logic commit;

    assign rd_act = hsp_pkg::cpu_read_active(cpu_rd_n, cpu_ce_n, cpu_dsel, cpu_iorq_n);

    hsp_edge_det #(.RST_VAL(1'b1), .DETECT_RISE(1'b1)) i_strb_edge (
        .clk(clk), .rst_n(rst_n), .sig(strb_n), .pulse(strb_rise)
    );

    hsp_edge_det #(.RST_VAL(1'b0), .DETECT_RISE(1'b0)) i_read_edge (
        .clk(clk), .rst_n(rst_n), .sig(rd_act), .pulse(read_done)
    );

    hsp_in_reg #(.W(DATA_W)) i_in_reg (
        .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .port_d(port_d),
        .ready(rdy_o), .cpu_read(rd_act), .strb_rise(strb_rise),
        .data_q(cpu_data), .commit(commit)
    );

    hsp_ready_ctrl i_ready (
        .clk(clk), .rst_n(rst_n), .commit(commit), .read_done(read_done),
        .cpu_read(rd_act), .ready(rdy_o)
    );

    hsp_irq_ctrl i_irq (
        .clk(clk), .rst_n(rst_n), .ien_load(ien_load), .ien_value(ien_value),
        .commit(commit), .int_ack(int_ack), .prio_in(prio_in), .int_req(int_req)
    );
endmodule

// File: rtl/hs_input_port_chk.sv
// Property checker for the handshaked input port, bound to the top.
// Observes ports only and keeps its own strobe history register.
module hs_input_port_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] port_d,
    input logic              strb_n,
    input logic              rdy_o,
    input logic              cpu_rd_n,
    input logic              cpu_ce_n,
    input logic              cpu_dsel,
    input logic              cpu_iorq_n,
    input logic [DATA_W-1:0] cpu_data,
    input logic              prio_in,
    input logic              int_ack,
    input logic              int_req
);
    logic rd_seen;
    logic strb_hist;

    assign rd_seen = !cpu_rd_n && !cpu_ce_n && cpu_dsel && !cpu_iorq_n;

    // Previous strobe level as seen by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_hist <= 1'b1;
        else        strb_hist <= strb_n;
    end

    AST_LOAD_TAKES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_n && rdy_o && !rd_seen) |=> (cpu_data == $past(port_d)));  // R1

    AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_n || !rdy_o || rd_seen) |=> $stable(cpu_data));  // R2

    AST_READ_FORCES_LOW: assert property (@(negedge clk) disable iff (!rst_n)
        rd_seen |=> !rdy_o);  // R5

    AST_READY_UP_AFTER_READ: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> !$past(rd_seen));  // R6

    AST_IRQ_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_req) && $stable(prio_in)) |-> $past(strb_n && !strb_hist));  // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !(strb_n && !strb_hist)) |=> !int_req);  // R8
endmodule

bind hs_input_port hs_input_port_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .port_d(port_d), .strb_n(strb_n), .rdy_o(rdy_o),
    .cpu_rd_n(cpu_rd_n), .cpu_ce_n(cpu_ce_n), .cpu_dsel(cpu_dsel),
    .cpu_iorq_n(cpu_iorq_n), .cpu_data(cpu_data), .prio_in(prio_in),
    .int_ack(int_ack), .int_req(int_req)
);

// File: tb/test_hs_input_port.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module test_hs_input_port;
    localparam int W  = 8;
    localparam int NV = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] port_d = '0;
    logic         strb_n = 1'b1;
    logic         rdy_o;
    logic         cpu_rd_n = 1'b1;
    logic         cpu_ce_n = 1'b0;
    logic         cpu_dsel = 1'b1;
    logic         cpu_iorq_n = 1'b1;
    logic [W-1:0] cpu_data;
    logic         ien_load = 1'b0;
    logic         ien_value = 1'b0;
    logic         prio_in = 1'b1;
    logic         int_ack = 1'b0;
    logic         int_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hs_input_port #(.DATA_W(W)) i_hs_input_port (
        .clk(clk), .rst_n(rst_n), .port_d(port_d), .strb_n(strb_n), .rdy_o(rdy_o),
        .cpu_rd_n(cpu_rd_n), .cpu_ce_n(cpu_ce_n), .cpu_dsel(cpu_dsel),
        .cpu_iorq_n(cpu_iorq_n), .cpu_data(cpu_data), .ien_load(ien_load),
        .ien_value(ien_value), .prio_in(prio_in), .int_ack(int_ack), .int_req(int_req)
    );

    // Vector: {req, strb_n, d, rd_n, ce_n, iorq_n, ack, exp_data, exp_rdy, exp_irq}
    localparam logic [26:0] VEC [NV] = '{
        {4'd1, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0},  // R1 capture
        {4'd3, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1},  // R3 commit, R7 irq
        {4'd2, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1},  // R2 blocked load
        {4'd3, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1},  // R3 empty rise ignored
        {4'd8, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},  // R8 ack
        {4'd5, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},  // R5 read
        {4'd6, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0},  // R6 read end
        {4'd4, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0},  // R4 chip disabled
        {4'd5, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},  // R5 read when empty
        {4'd2, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},  // R2 strobe in read
        {4'd6, 1'b0, 8'h77, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0},  // R6 ready back
        {4'd1, 1'b0, 8'h77, 1'b1, 1'b0, 1'b1, 1'b0, 8'h77, 1'b1, 1'b0},  // R1 held strobe loads
        {4'd3, 1'b1, 8'h77, 1'b1, 1'b0, 1'b1, 1'b0, 8'h77, 1'b0, 1'b1},  // R3 commit
        {4'd8, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 1'b0},  // R8 ack during read
        {4'd6, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h77, 1'b1, 1'b0},  // R6
        {4'd2, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0},  // R2 strobe starts with read
        {4'd3, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 8'h77, 1'b1, 1'b0}   // R3 uncaptured rise
    };

    task automatic chk(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [W-1:0] d, input logic r,
                           input logic q);
        chk(req, "data", cpu_data, d);
        chk(req, "ready", {7'd0, rdy_o}, {7'd0, r});
        chk(req, "int_req", {7'd0, int_req}, {7'd0, q});
    endtask

    // One cycle: inputs set now are seen by the next rising and falling edge.
    task automatic cycle();
        @(negedge clk);
        #2;
    endtask

    task automatic idle();
        strb_n = 1'b1; cpu_rd_n = 1'b1; cpu_ce_n = 1'b0; cpu_dsel = 1'b1;
        cpu_iorq_n = 1'b1; int_ack = 1'b0; ien_load = 1'b0;
    endtask

    task automatic do_read();
        cpu_rd_n = 1'b0; cpu_iorq_n = 1'b0; cycle();
        idle(); cycle();
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycle(); cycle();
        chk_all("R9", 8'h00, 1'b1, 1'b0);              // R9 reset state
        rst_n = 1'b1;
        ien_load = 1'b1; ien_value = 1'b1; cycle();    // R10 enable on
        ien_load = 1'b0;

        for (int i = 0; i < NV; i++) begin
            strb_n = VEC[i][22]; port_d = VEC[i][21:14]; cpu_rd_n = VEC[i][13];
            cpu_ce_n = VEC[i][12]; cpu_iorq_n = VEC[i][11]; int_ack = VEC[i][10];
            cycle();
            chk_all($sformatf("R%0d", VEC[i][26:23]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end
        idle();

        // R10: interrupts disabled, commit raises no request
        ien_load = 1'b1; ien_value = 1'b0; cycle(); ien_load = 1'b0;
        strb_n = 1'b0; port_d = 8'h11; cycle();
        strb_n = 1'b1; cycle();
        chk_all("R10", 8'h11, 1'b0, 1'b0);
        do_read();

        // R4: data select low is not a read
        cpu_rd_n = 1'b0; cpu_iorq_n = 1'b0; cpu_dsel = 1'b0; cycle();
        chk_all("R4", 8'h11, 1'b1, 1'b0);
        idle();

        // R7: priority masks the request, then releases it
        ien_load = 1'b1; ien_value = 1'b1; cycle(); ien_load = 1'b0;
        strb_n = 1'b0; port_d = 8'h22; cycle();
        prio_in = 1'b0; strb_n = 1'b1; cycle();
        chk_all("R7", 8'h22, 1'b0, 1'b0);
        prio_in = 1'b1; #1;
        chk("R7", "int_req prio", {7'd0, int_req}, 8'h01);
        do_read();

        // R8: acknowledge together with a new commit keeps the request
        strb_n = 1'b0; port_d = 8'h33; cycle();
        strb_n = 1'b1; int_ack = 1'b1; cycle();
        chk_all("R8", 8'h33, 1'b0, 1'b1);
        idle(); int_ack = 1'b1; cycle();
        chk_all("R8", 8'h33, 1'b0, 1'b0);
        idle();

        // R9: mid-run reset clears state and interrupt enable
        rst_n = 1'b0; cycle();
        chk_all("R9", 8'h00, 1'b1, 1'b0);
        rst_n = 1'b1;
        strb_n = 1'b0; port_d = 8'h44; cycle();
        strb_n = 1'b1; cycle();
        chk_all("R9", 8'h44, 1'b0, 1'b0);
        idle(); cycle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule